// File: doc/BRIEF.md
# Multi-Source Event Timestamp Latch

This block keeps several running time counters and freezes their values when events arrive. A 48-bit counter on the main clock (25 ns period) is captured at every accepted trigger leading edge. A second 48-bit counter runs on a separate external clock (10 ns period). A trigger edge is handed to that domain and the captured count is returned. A third value is taken at the same trigger. It holds a 32-bit count of main-clock cycles since the last macro-pulse leading edge, with three status flags above it. The main counter is also captured at each macro-pulse leading edge and at each leading edge of the block-window input.

A pulse on `acq_start` marks the start of acquisition. It zeroes the main counter, the macro-pulse-relative counter and the macro-pulse-seen flag, and it also zeroes the external counter through a toggle crossing. Each captured value is read as a low word (bits 31..0) and a high word (bits 47..32, zero-extended) through a registered select-and-read port. A captured group is protected until its high word has been read, unless overwriting is allowed.

Top module: `evt_stamp_latch`

## Requirements
- R1: After reset, every readable word returns zero.
- R2: The main counter is zeroed on a clock edge where `acq_start` is high and otherwise steps by one per edge. If `trig_in` is first sampled high at edge k after being low at edge k-1, the trigger group captures the main counter value held just before edge k+2. Code 0 reads bits 31..0 of this value and code 1 reads bits 47..32.
- R3: The third value captured at the trigger has this layout. Bits 31..0 count main-clock edges since the last recognised macro-pulse edge or `acq_start`. Bit 32 is the synchronised `mp_in` level. Bit 33 is set once a macro-pulse edge has been recognised since `acq_start`. Bit 34 is the synchronised `bw_in` level. Bits 47..35 are zero. Code 4 reads the low word and code 5 the high word.
- R4: A leading edge on `mp_in` captures the main counter with the same two-edge latency as R2. Code 6 reads the low word and code 7 the high word.
- R5: A leading edge on `bw_in` captures the main counter with the same latency. Code 8 reads the low word and code 9 the high word.
- R6: The external counter steps on each `ext_clk` edge and is zeroed a few external cycles after `acq_start`. An accepted trigger returns its value to the main domain, readable within 20 main cycles. It is read with code 2 (low word) and code 3 (high word). A later trigger returns a larger value.
- R7: A read with `rd_en` high presents the selected word on `rd_data` one edge later, and `rd_data` holds between reads. A high word carries bits 47..32 in bits 15..0 with bits 31..16 zero. Codes 10 to 15 return zero.
- R8: While a group is held and `allow_ovr` is low, a new edge leaves that group unchanged, including the external stamp. Reading code 5 releases the trigger group, code 7 the macro-pulse group and code 9 the block-window group. With `allow_ovr` high, every edge overwrites.
- R9: When a release read and a new edge of the same group fall on one clock edge, the read returns the old value and the new value is latched, and the group becomes held again.
- R10: Reading a low word does not release its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (25 ns) |
| rst | input | 1 | Synchronous active-high reset, main domain |
| ext_clk | input | 1 | External counting clock (10 ns) |
| ext_rst | input | 1 | Synchronous active-high reset, external domain |
| acq_start | input | 1 | Start-of-acquisition pulse, zeroes the counters |
| trig_in | input | 1 | Acquisition trigger, asynchronous level |
| mp_in | input | 1 | Macro-pulse input, asynchronous level |
| bw_in | input | 1 | Block-window input, asynchronous level |
| allow_ovr | input | 1 | Allows held groups to be overwritten |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 4 | Word select code |
| rd_data | output | 32 | Registered read word |

## Verification
The read port and the edge detectors share a clock edge. A read of a group's high word can therefore release that group in the same cycle that a fresh edge wants to load it. The bench provokes this by raising `trig_in` and placing a code-5 read exactly two clock edges after the first high sample. The behavioural model decides independently that the read shows the old flags while the latch takes the new values, and a following low-word read and a blocked re-trigger confirm that the group ended up held with the new capture.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;

  // read select codes; odd codes are the high words
  localparam sel_t SEL_T1_LO = 4'd0;
  localparam sel_t SEL_T1_HI = 4'd1;
  localparam sel_t SEL_T2_LO = 4'd2;
  localparam sel_t SEL_T2_HI = 4'd3;
  localparam sel_t SEL_T3_LO = 4'd4;
  localparam sel_t SEL_T3_HI = 4'd5;
  localparam sel_t SEL_T4_LO = 4'd6;
  localparam sel_t SEL_T4_HI = 4'd7;
  localparam sel_t SEL_BW_LO = 4'd8;
  localparam sel_t SEL_BW_HI = 4'd9;

  // bit order of the synchronised event inputs
  typedef struct packed {
    logic bw;
    logic mp;
    logic trig;
  } evt_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evt_slot.sv
module evt_slot #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         release_i,
  input  logic         ovr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         take
);
  logic held;

  // a release on the same edge frees the slot for the incoming edge
  assign take = load && (!held || ovr || release_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      held <= 1'b0;
    end else if (take) begin
      q    <= d;
      held <= 1'b1;
    end else if (release_i) begin
      held <= 1'b0;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    held && !release_i && !ovr |=> $stable(q)); // R8
endmodule

// File: rtl/evt_ext_stamp.sv
module evt_ext_stamp #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_clk,
  input  logic         ext_rst,
  input  logic         acq_start,
  input  logic         launch,
  output logic [W-1:0] stamp
);
  localparam logic [W-1:0] ONE = W'(1);

  // main-domain side
  logic acq_tgl, req_tgl, busy, ack_prev, ack_s;
  // external-domain side
  logic         acq_s, req_s, acq_p, req_p, ack_tgl;
  logic [W-1:0] ecnt, cap;

  evt_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_tgl  <= 1'b0;
      req_tgl  <= 1'b0;
      busy     <= 1'b0;
      ack_prev <= 1'b0;
      stamp    <= '0;
    end else begin
      if (acq_start) acq_tgl <= ~acq_tgl;
      if (launch && !busy) begin
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end else if (ack_s != ack_prev) begin
        busy <= 1'b0;
      end
      ack_prev <= ack_s;
      // cap is stable from before the ack toggle until the next request
      if (ack_s != ack_prev) stamp <= cap;
    end
  end

  evt_sync #(.W(2), .STAGES(STAGES)) u_req_sync (
    .clk(ext_clk), .rst(ext_rst), .d({acq_tgl, req_tgl}), .q({acq_s, req_s})
  );

  always_ff @(posedge ext_clk) begin
    if (ext_rst) begin
      acq_p   <= 1'b0;
      req_p   <= 1'b0;
      ecnt    <= '0;
      cap     <= '0;
      ack_tgl <= 1'b0;
    end else begin
      acq_p <= acq_s;
      req_p <= req_s;
      if (acq_s != acq_p) ecnt <= '0;
      else                ecnt <= ecnt + ONE;
      if (req_s != req_p) begin
        cap     <= ecnt;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

  AST_ACK_FOLLOWS: assert property (@(posedge ext_clk) disable iff (ext_rst)
    (req_s != req_p) |=> (ack_tgl != $past(ack_tgl))); // R6
endmodule

// File: rtl/evt_stamp_latch.sv
module evt_stamp_latch
  import evt_stamp_pkg::*;
#(
  parameter int STAMP_W = 48,
  parameter int WORD_W  = 32,
  parameter int REL_W   = 32,
  parameter int STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic              ext_rst,
  input  logic              acq_start,
  input  logic              trig_in,
  input  logic              mp_in,
  input  logic              bw_in,
  input  logic              allow_ovr,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data
);
  localparam int HI_W  = STAMP_W - WORD_W;
  localparam int HI_PD = WORD_W - HI_W;
  localparam int PAD_W = STAMP_W - REL_W - 3;
  localparam logic [STAMP_W-1:0] ONE_S = STAMP_W'(1);
  localparam logic [REL_W-1:0]   ONE_R = REL_W'(1);

  evt_t evt_s, evt_p, evt_e;

  evt_sync #(.W(3), .STAGES(STAGES)) u_evt_sync (
    .clk(clk), .rst(rst), .d({bw_in, mp_in, trig_in}), .q(evt_s)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_p <= '0;
    else     evt_p <= evt_s;
  end
  assign evt_e = evt_s & ~evt_p;

  // running counters in the main domain
  logic [STAMP_W-1:0] cnt_int;
  logic [REL_W-1:0]   rel_cnt;
  logic               mp_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_int <= '0;
      rel_cnt <= '0;
      mp_seen <= 1'b0;
    end else begin
      cnt_int <= acq_start ? '0 : cnt_int + ONE_S;
      rel_cnt <= (acq_start || evt_e.mp) ? '0 : rel_cnt + ONE_R;
      if (acq_start)     mp_seen <= 1'b0;
      else if (evt_e.mp) mp_seen <= 1'b1;
    end
  end

  logic [STAMP_W-1:0] rel_word;
  assign rel_word = {{PAD_W{1'b0}}, evt_s.bw, mp_seen, evt_s.mp, rel_cnt};

  // releases come from reads of each group's high word
  logic rel_trig, rel_mp, rel_bw;
  assign rel_trig = rd_en && (rd_sel == SEL_T3_HI);
  assign rel_mp   = rd_en && (rd_sel == SEL_T4_HI);
  assign rel_bw   = rd_en && (rd_sel == SEL_BW_HI);

  logic [STAMP_W-1:0] t1_q, t2_q, t3_q, t4_q, bw_q;
  logic               trig_take, mp_take, bw_take;

  evt_slot #(.W(2*STAMP_W)) u_trig_slot (
    .clk(clk), .rst(rst), .load(evt_e.trig), .release_i(rel_trig), .ovr(allow_ovr),
    .d({rel_word, cnt_int}), .q({t3_q, t1_q}), .take(trig_take)
  );

  evt_slot #(.W(STAMP_W)) u_mp_slot (
    .clk(clk), .rst(rst), .load(evt_e.mp), .release_i(rel_mp), .ovr(allow_ovr),
    .d(cnt_int), .q(t4_q), .take(mp_take)
  );

  evt_slot #(.W(STAMP_W)) u_bw_slot (
    .clk(clk), .rst(rst), .load(evt_e.bw), .release_i(rel_bw), .ovr(allow_ovr),
    .d(cnt_int), .q(bw_q), .take(bw_take)
  );

  evt_ext_stamp #(.W(STAMP_W), .STAGES(STAGES)) u_ext (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_rst(ext_rst),
    .acq_start(acq_start), .launch(trig_take), .stamp(t2_q)
  );

  // read mux and registered output
  function automatic logic [WORD_W-1:0] lo_w(input logic [STAMP_W-1:0] x);
    return x[WORD_W-1:0];
  endfunction
  function automatic logic [WORD_W-1:0] hi_w(input logic [STAMP_W-1:0] x);
    return {{HI_PD{1'b0}}, x[STAMP_W-1:WORD_W]};
  endfunction

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    case (rd_sel)
      SEL_T1_LO: rd_word = lo_w(t1_q);
      SEL_T1_HI: rd_word = hi_w(t1_q);
      SEL_T2_LO: rd_word = lo_w(t2_q);
      SEL_T2_HI: rd_word = hi_w(t2_q);
      SEL_T3_LO: rd_word = lo_w(t3_q);
      SEL_T3_HI: rd_word = hi_w(t3_q);
      SEL_T4_LO: rd_word = lo_w(t4_q);
      SEL_T4_HI: rd_word = hi_w(t4_q);
      SEL_BW_LO: rd_word = lo_w(bw_q);
      SEL_BW_HI: rd_word = hi_w(bw_q);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  AST_T1_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    trig_take |=> t1_q == $past(cnt_int)); // R2
  AST_T3_FLAGS: assert property (@(posedge clk) disable iff (rst)
    trig_take |=> (t3_q[REL_W+2] == $past(evt_s.bw)) && (t3_q[REL_W] == $past(evt_s.mp))); // R3
  AST_MP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    mp_take |=> t4_q == $past(cnt_int)); // R4
  AST_BW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    bw_take |=> bw_q == $past(cnt_int)); // R5
  AST_HI_PAD: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel[0] && (rd_sel <= SEL_BW_HI) |=> rd_data[WORD_W-1:HI_W] == '0); // R7
  AST_BAD_SEL: assert property (@(posedge clk) disable iff (rst)
    rd_en && (rd_sel > SEL_BW_HI) |=> rd_data == '0); // R7
endmodule

// File: tb/evt_stamp_latch_test.sv
`timescale 1ns/100ps
module evt_stamp_latch_test;
  localparam realtime CLK_PERIOD = 25.0;
  localparam realtime EXT_PERIOD = 10.0;

  logic        clk = 0, ext_clk = 0, rst = 1, ext_rst = 1;
  logic        acq_start = 0, trig_in = 0, mp_in = 0, bw_in = 0, allow_ovr = 0;
  logic        rd_en = 0;
  logic [3:0]  rd_sel = 0;
  logic [31:0] rd_data;

  evt_stamp_latch uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .ext_rst(ext_rst),
    .acq_start(acq_start), .trig_in(trig_in), .mp_in(mp_in), .bw_in(bw_in),
    .allow_ovr(allow_ovr), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;
  initial begin #1; forever #(EXT_PERIOD/2) ext_clk = ~ext_clk; end

  int total = 0, bad = 0, ecount = 0, e_base = 0;
  bit done = 0, cmp_on = 0;
  always @(posedge ext_clk) ecount++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_true(string req, bit ok, logic [31:0] act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%s", req, act, exp);
    end
  endtask

  // behavioural reference: histories of input samples and the stated latch rules
  logic [47:0] m_cnt, m_t1, m_t3, m_t4, m_bw;
  logic [31:0] m_rel, m_rd;
  bit          m_seen, h_t, h_m, h_b, m_skip;
  bit [2:0]    th, mh, bh;
  string       m_tag = "R1";

  function automatic logic [31:0] m_word(int s);
    case (s)
      0: return m_t1[31:0];
      1: return {16'h0, m_t1[47:32]};
      4: return m_t3[31:0];
      5: return {16'h0, m_t3[47:32]};
      6: return m_t4[31:0];
      7: return {16'h0, m_t4[47:32]};
      8: return m_bw[31:0];
      9: return {16'h0, m_bw[47:32]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string m_req(int s);
    if (s <= 1) return "R2";
    if (s <= 5) return "R3";
    if (s <= 7) return "R4";
    if (s <= 9) return "R5";
    return "R7";
  endfunction

  always @(posedge clk) begin : model
    bit te, me, be, rt, rm, rb;
    if (rst) begin
      m_cnt = 0; m_t1 = 0; m_t3 = 0; m_t4 = 0; m_bw = 0; m_rel = 0; m_rd = 0;
      m_seen = 0; h_t = 0; h_m = 0; h_b = 0; m_skip = 0; m_tag = "R1";
      th = 0; mh = 0; bh = 0;
    end else begin
      te = th[1] && !th[2];
      me = mh[1] && !mh[2];
      be = bh[1] && !bh[2];
      rt = rd_en && rd_sel == 5;
      rm = rd_en && rd_sel == 7;
      rb = rd_en && rd_sel == 9;
      if (rd_en) begin
        m_rd   = m_word(int'(rd_sel));
        m_skip = (rd_sel == 2) || (rd_sel == 3);
        m_tag  = m_req(int'(rd_sel));
      end
      if (te && (!h_t || allow_ovr || rt)) begin
        m_t1 = m_cnt;
        m_t3 = {13'h0, bh[1], m_seen, mh[1], m_rel};
        h_t  = 1;
      end else if (rt) h_t = 0;
      if (me && (!h_m || allow_ovr || rm)) begin m_t4 = m_cnt; h_m = 1; end
      else if (rm) h_m = 0;
      if (be && (!h_b || allow_ovr || rb)) begin m_bw = m_cnt; h_b = 1; end
      else if (rb) h_b = 0;
      m_rel  = (acq_start || me) ? 32'h0 : m_rel + 1;
      m_seen = acq_start ? 1'b0 : (me ? 1'b1 : m_seen);
      m_cnt  = acq_start ? 48'h0 : m_cnt + 1;
      th = {th[1:0], trig_in};
      mh = {mh[1:0], mp_in};
      bh = {bh[1:0], bw_in};
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) if (cmp_on && !m_skip) check(m_tag, rd_data, m_rd);

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int s, output logic [31:0] v);
    rd_en = 1; rd_sel = 4'(s);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic pulse_trig();
    trig_in = 1; cyc(4); trig_in = 0; cyc(4);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    logic [31:0] v, v1, vc, t2a, t2b;
    int e_trig;
    cyc(1); cmp_on = 1; cyc(5);
    rst = 0; ext_rst = 0; cyc(2);

    for (int s = 0; s < 10; s++) begin rd(s, v); check("R1", v, 32'h0); end

    acq_start = 1; e_base = ecount; cyc(1); acq_start = 0; cyc(30);
    mp_in = 1; bw_in = 1; cyc(12);
    e_trig = ecount - e_base;
    pulse_trig(); cyc(20);
    for (int s = 0; s < 10; s++) begin
      rd(s, v);
      if (s == 2) t2a = v;
      if (s == 5) check("R3", v, 32'h7);
      if (s == 1) check("R2", v, 32'h0);
    end
    check_true("R6", int'(t2a) >= e_trig - 2 && int'(t2a) <= e_trig + 14, t2a, "near ext count");
    rd(3, v); check("R6", v, 32'h0);

    // trigger group now released: capture, read low word only, retrigger
    pulse_trig(); cyc(20);
    rd(0, v1); rd(2, t2b);
    check_true("R6", t2b > t2a, t2b, "above first ext stamp");
    pulse_trig(); cyc(20);
    rd(0, v); check("R10", v, v1);
    check("R8", v, v1);
    rd(2, v); check("R8", v, t2b);

    allow_ovr = 1; pulse_trig(); cyc(20);
    rd(0, vc);
    check_true("R8", vc != v1, vc, "new value with overwrite");
    allow_ovr = 0;

    // release read and trigger edge on the same clock edge
    trig_in = 1; cyc(2);
    rd_en = 1; rd_sel = 4'd5;
    @(negedge clk);
    rd_en = 0;
    cyc(3); trig_in = 0; cyc(4);
    rd(0, v);
    check("R9", v, m_t1[31:0]);
    check_true("R9", v != vc, v, "new capture after collision");
    vc = v;
    pulse_trig(); cyc(10);
    rd(0, v); check("R9", v, vc);

    // flags with macro pulse and window both low
    rd(5, v);
    mp_in = 0; bw_in = 0; cyc(10);
    pulse_trig(); cyc(5);
    rd(5, v); check("R3", v, 32'h2);

    // second macro-pulse edge and relative counter restart
    rd(7, v);
    mp_in = 1; cyc(10);
    rd(6, v); check("R4", v, m_t4[31:0]);
    pulse_trig();
    rd(4, v);
    check_true("R3", v < 32'd20, v, "small count after macro pulse");
    rd(7, v); check("R4", v, 32'h0);

    // second block-window edge
    rd(9, v);
    bw_in = 1; cyc(10);
    rd(8, v); check("R5", v, m_bw[31:0]);

    rd(12, v); check("R7", v, 32'h0);
    rd(15, v); check("R7", v, 32'h0);
    cyc(3);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule